// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller with Special Mask

The controller collects eight interrupt request lines, holds pending, in-service and mask state in three byte-wide registers, and picks the most urgent unmasked request by scanning levels from a rotatable lowest-priority pointer. When a grantable request exists it raises its interrupt output. A host pulse on the acknowledge input moves the winning level from pending to in-service and returns its 3-bit level number one cycle later.

Software reaches the block through a byte write port with a single address bit. With the address bit high, the byte loads the mask. With it low, the byte carries an initialisation command or one of two operation commands. The operation commands end service (non-specific, specific or rotating), set the priority pointer, choose which register the read port shows, and turn special mask mode on or off. In special mask mode the in-service register stops blocking lower levels, so only the mask holds a level back. A non-specific end of service then passes over in-service levels that are masked.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A rising edge on `irq_in[i]` sets pending bit i on the next clock. A pending bit clears on the clock after its input is seen low. An input held high is not latched again after its level has been acknowledged.
- R2: A write with `a0`=1 loads the mask from `wdata`. Reading with `a0`=1 returns the mask. A masked level never raises `int_out`.
- R3: Levels are scanned in the order pointer+1, pointer+2, … modulo 8. The initialisation command sets the pointer to 7, which makes level 0 the most urgent. An operation command with `wdata[7:5]`=110 loads the pointer from `wdata[2:0]`.
- R4: With special mask mode off, a pending level is granted only when no in-service bit of equal or higher priority is set.
- R5: When the initialisation command was written with bit 0 set (nested-cascade variant), the in-service bit of level 2 never blocks any level.
- R6: `ack` with a grantable request clears that level's pending bit, sets its in-service bit, and presents the level on `ack_level` with `ack_valid` high on the following cycle. `int_out` is low whenever no grantable request remains.
- R7: `ack` with no grantable request returns level 7 and leaves the pending and in-service registers unchanged.
- R8: An operation command with `wdata[7:5]`=001 clears the highest-priority in-service bit. With 101 it also sets the pointer to the cleared level. With 011 it clears the in-service bit `wdata[2:0]`.
- R9: A byte with `a0`=0, bit 4 clear and bit 3 set is the mode command. Its bit 6 set loads special mask mode from bit 5, and its bit 6 clear leaves the mode unchanged. Bits 1:0 = 10 select the pending register for reads with `a0`=0, and 11 select the in-service register.
- R10: With special mask mode on, any unmasked pending level raises `int_out`, whatever is in service.
- R11: With special mask mode on, the non-specific end of service clears the highest-priority in-service bit whose mask bit is clear. Masked in-service bits are skipped.
- R12: A byte with `a0`=0 and bit 4 set is the initialisation command. It clears the mask, the in-service register and special mask mode, sets the pointer to 7, and selects the pending register for reads.
- R13: An acknowledge and an end-of-service command in the same cycle both take effect. The clear acts on the old in-service state, and the new grant is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| a0 | input | 1 | Address bit: 1 = mask, 0 = command / pending or in-service read |
| wdata | input | 8 | Write byte |
| rd_data | output | 8 | Register selected by `a0` and the read select |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | Acknowledge pulse from the host |
| int_out | output | 1 | A grantable request exists |
| ack_valid | output | 1 | `ack_level` is valid this cycle |
| ack_level | output | 3 | Level granted by the last acknowledge |

## Verification
The acknowledge and an end-of-service write both rewrite the in-service register, so they can fall in the same cycle. The bench holds level 1 in service with level 0 pending and then drives `ack` together with a non-specific end-of-service write in a single clock. It expects level 0 on `ack_level` and an in-service register of exactly bit 0 when read back, which shows that the clear acted on the old state and the grant was not lost. Special mask mode is also entered while a masked level is in service, to check that granting and ending service each follow the mask rather than the in-service register.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // operation-command action codes, carried in wdata[7:5]
  localparam logic [2:0] OP_NS_EOI  = 3'b001;
  localparam logic [2:0] OP_SP_EOI  = 3'b011;
  localparam logic [2:0] OP_ROT_EOI = 3'b101;
  localparam logic [2:0] OP_SET_PRI = 3'b110;

  typedef struct packed {
    logic init;
    logic mask;
    logic op;
    logic mode;
  } cmd_t;
endpackage

// File: rtl/intc_cmd_dec.sv
module intc_cmd_dec #(
  parameter int DW = 8
) (
  input  logic          wr_en,
  input  logic          a0,
  input  logic [DW-1:0] wdata,
  output intc_pkg::cmd_t cmd
);
  always_comb begin
    cmd      = '0;
    cmd.mask = wr_en & a0;
    cmd.init = wr_en & ~a0 & wdata[4];
    cmd.op   = wr_en & ~a0 & ~wdata[4] & ~wdata[3];
    cmd.mode = wr_en & ~a0 & ~wdata[4] & wdata[3];
  end
endmodule

// File: rtl/intc_prio_scan.sv
module intc_prio_scan #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] cand,
  input  logic [N-1:0] stop,
  input  logic [W-1:0] lowp,
  output logic         found,
  output logic [W-1:0] idx
);
  logic         done;
  logic [W-1:0] lvl;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    done  = 1'b0;
    lvl   = '0;
    for (int k = 0; k < N; k++) begin
      lvl = lowp + W'(k + 1);
      if (!done) begin
        if (stop[lvl]) begin
          done = 1'b1;
        end else if (cand[lvl]) begin
          found = 1'b1;
          idx   = lvl;
          done  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/intc_req_latch.sv
module intc_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] take,
  output logic [N-1:0] irr
);
  logic [N-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev <= '0;
      irr  <= '0;
    end else begin
      prev <= irq_in;
      irr  <= (irr | (irq_in & ~prev)) & irq_in & ~take;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N_LVL     = 8,
  parameter int CASC_LVL  = 2,
  parameter int LW        = $clog2(N_LVL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             a0,
  input  logic [N_LVL-1:0] wdata,
  output logic [N_LVL-1:0] rd_data,
  input  logic [N_LVL-1:0] irq_in,
  input  logic             ack,
  output logic             int_out,
  output logic             ack_valid,
  output logic [LW-1:0]    ack_level
);
  import intc_pkg::*;

  localparam logic [LW-1:0]    SPUR_LVL = LW'(N_LVL - 1);
  localparam logic [N_LVL-1:0] CASC_BIT = N_LVL'(1) << CASC_LVL;

  cmd_t             cmd;
  logic [N_LVL-1:0] irr_q, isr_q, imr_q, isr_nx, take_vec, blk, eoi_cand;
  logic [N_LVL-1:0] clr_vec;
  logic [LW-1:0]    lowp_q, g_idx, e_idx;
  logic             smm_q, nest_q, rd_isr_q, g_found, e_found, take;
  logic [2:0]       op_code;

  intc_cmd_dec #(.DW(N_LVL)) u_dec (
    .wr_en (wr_en),
    .a0    (a0),
    .wdata (wdata),
    .cmd   (cmd)
  );

  intc_req_latch #(.N(N_LVL)) u_req (
    .clk    (clk),
    .rst    (rst),
    .irq_in (irq_in),
    .take   (take_vec),
    .irr    (irr_q)
  );

  // blocking set: none in special mask mode, cascade level exempt when nested
  always_comb begin
    if (smm_q)       blk = '0;
    else if (nest_q) blk = isr_q & ~CASC_BIT;
    else             blk = isr_q;
  end

  intc_prio_scan #(.N(N_LVL), .W(LW)) u_grant (
    .cand  (irr_q & ~imr_q),
    .stop  (blk),
    .lowp  (lowp_q),
    .found (g_found),
    .idx   (g_idx)
  );

  assign eoi_cand = smm_q ? (isr_q & ~imr_q) : isr_q;

  intc_prio_scan #(.N(N_LVL), .W(LW)) u_eoi (
    .cand  (eoi_cand),
    .stop  ({N_LVL{1'b0}}),
    .lowp  (lowp_q),
    .found (e_found),
    .idx   (e_idx)
  );

  assign int_out  = g_found;
  assign take     = ack & g_found;
  assign take_vec = take ? (N_LVL'(1) << g_idx) : '0;
  assign op_code  = wdata[7:5];

  always_comb begin
    clr_vec = '0;
    if (cmd.op) begin
      if ((op_code == OP_NS_EOI || op_code == OP_ROT_EOI) && e_found)
        clr_vec = N_LVL'(1) << e_idx;
      else if (op_code == OP_SP_EOI)
        clr_vec = N_LVL'(1) << wdata[LW-1:0];
    end
    isr_nx = (isr_q & ~clr_vec) | take_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imr_q     <= '0;
      isr_q     <= '0;
      smm_q     <= 1'b0;
      nest_q    <= 1'b0;
      rd_isr_q  <= 1'b0;
      lowp_q    <= SPUR_LVL;
      ack_valid <= 1'b0;
      ack_level <= '0;
    end else begin
      ack_valid <= ack;
      if (ack) ack_level <= take ? g_idx : SPUR_LVL;
      if (cmd.init) begin
        imr_q    <= '0;
        isr_q    <= '0;
        smm_q    <= 1'b0;
        rd_isr_q <= 1'b0;
        nest_q   <= wdata[0];
        lowp_q   <= SPUR_LVL;
      end else begin
        isr_q <= isr_nx;
        if (cmd.mask) imr_q <= wdata;
        if (cmd.mode) begin
          if (wdata[6]) smm_q    <= wdata[5];
          if (wdata[1]) rd_isr_q <= wdata[0];
        end
        if (cmd.op) begin
          if (op_code == OP_SET_PRI)                lowp_q <= wdata[LW-1:0];
          else if (op_code == OP_ROT_EOI && e_found) lowp_q <= e_idx;
        end
      end
    end
  end

  assign rd_data = a0 ? imr_q : (rd_isr_q ? isr_q : irr_q);
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_LVL = 8,
  parameter int LW    = $clog2(N_LVL)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             a0,
  input logic [N_LVL-1:0] wdata,
  input logic             ack,
  input logic             int_out,
  input logic             ack_valid,
  input logic [LW-1:0]    ack_level,
  input logic [N_LVL-1:0] irr_q,
  input logic [N_LVL-1:0] isr_q,
  input logic [N_LVL-1:0] imr_q,
  input logic             smm_q,
  input logic [LW-1:0]    lowp_q
);
  logic init_w, mode_keep_w;
  assign init_w      = wr_en && !a0 && wdata[4];
  assign mode_keep_w = wr_en && !a0 && !wdata[4] && wdata[3] && !wdata[6];

  p_init_state_r12: assert property (@(posedge clk) disable iff (rst)
    init_w |=> (!smm_q && lowp_q == LW'(N_LVL - 1) && imr_q == '0 && isr_q == '0));

  p_mode_kept_r9: assert property (@(posedge clk) disable iff (rst)
    mode_keep_w |=> $stable(smm_q));

  p_int_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
    int_out |-> ((irr_q & ~imr_q) != '0));

  p_smm_raise_r10: assert property (@(posedge clk) disable iff (rst)
    (smm_q && ((irr_q & ~imr_q) != '0)) |-> int_out);

  p_ack_to_isr_r6: assert property (@(posedge clk) disable iff (rst)
    (ack && int_out && !wr_en) |=> (ack_valid && isr_q[ack_level]));

  p_spurious_r7: assert property (@(posedge clk) disable iff (rst)
    (ack && !int_out && !wr_en) |=> (ack_level == LW'(N_LVL - 1) && $stable(isr_q)));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.N_LVL(N_LVL), .LW(LW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .a0        (a0),
  .wdata     (wdata),
  .ack       (ack),
  .int_out   (int_out),
  .ack_valid (ack_valid),
  .ack_level (ack_level),
  .irr_q     (irr_q),
  .isr_q     (isr_q),
  .imr_q     (imr_q),
  .smm_q     (smm_q),
  .lowp_q    (lowp_q)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, a0 = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0, irq_in = '0, rd_data;
  logic       int_out, ack_valid;
  logic [2:0] ack_level;
  int         n_run = 0, n_fail = 0;
  logic [7:0] v;

  always #4 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .a0(a0), .wdata(wdata),
    .rd_data(rd_data), .irq_in(irq_in), .ack(ack), .int_out(int_out),
    .ack_valid(ack_valid), .ack_level(ack_level)
  );

  // {pointer, mask, requests, expect int_out, expect level}
  localparam logic [22:0] VEC [0:7] = '{
    {3'd7, 8'h00, 8'h0A, 1'b1, 3'd1},
    {3'd7, 8'h02, 8'h0A, 1'b1, 3'd3},
    {3'd2, 8'h00, 8'h0A, 1'b1, 3'd3},
    {3'd3, 8'h00, 8'h0A, 1'b1, 3'd1},
    {3'd7, 8'hFF, 8'h0A, 1'b0, 3'd7},
    {3'd5, 8'h00, 8'h81, 1'b1, 3'd7},
    {3'd0, 8'h00, 8'h81, 1'b1, 3'd7},
    {3'd7, 8'h00, 8'h81, 1'b1, 3'd0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; a0 = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; a0 = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] q);
    a0 = a; #1; q = rd_data; a0 = 1'b0;
  endtask

  task automatic pulse_ack;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic set_irq(input logic [7:0] x);
    irq_in = x;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    check("R6 reset int_out", {7'd0, int_out}, 8'h00);
    check("R6 reset ack_valid", {7'd0, ack_valid}, 8'h00);
    rd(1'b1, v); check("R2 reset mask", v, 8'h00);
    rd(1'b0, v); check("R1 reset pending", v, 8'h00);

    // R1 edge latch and clear on deassert
    set_irq(8'h08);
    rd(1'b0, v); check("R1 edge sets pending", v, 8'h08);
    set_irq(8'h00);
    rd(1'b0, v); check("R1 low clears pending", v, 8'h00);

    // vector table: R3 order, R2 mask, R6 ack, R7 spurious
    for (int i = 0; i < 8; i++) begin
      wr(1'b0, 8'h10);
      wr(1'b0, {3'b110, 2'b00, VEC[i][22:20]});
      wr(1'b1, VEC[i][19:12]);
      rd(1'b1, v); check("R2 mask readback", v, VEC[i][19:12]);
      set_irq(VEC[i][11:4]);
      check("R3 int_out", {7'd0, int_out}, {7'd0, VEC[i][3]});
      pulse_ack;
      check("R6 ack_valid", {7'd0, ack_valid}, 8'h01);
      check("R3 ack_level", {5'd0, ack_level}, {5'd0, VEC[i][2:0]});
      check("R6 int_out drops", {7'd0, int_out}, 8'h00);
      if (!VEC[i][3]) begin
        rd(1'b0, v); check("R7 pending kept", v, VEC[i][11:4]);
        wr(1'b0, 8'h0B);
        rd(1'b0, v); check("R7 in-service kept", v, 8'h00);
      end
      set_irq(8'h00);
    end

    // R1 held input not relatched; R4 nesting
    wr(1'b0, 8'h10);
    set_irq(8'h02); pulse_ack;
    check("R4 first grant", {5'd0, ack_level}, 8'h01);
    rd(1'b0, v); check("R1 held input not relatched", v, 8'h00);
    set_irq(8'h0A);
    check("R4 lower level blocked", {7'd0, int_out}, 8'h00);
    set_irq(8'h0B);
    check("R4 higher level granted", {7'd0, int_out}, 8'h01);
    pulse_ack;
    check("R4 nested level", {5'd0, ack_level}, 8'h00);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R8 non-specific clears top", v, 8'h02);
    set_irq(8'h00);

    // R5 cascade level exempt in nested variant
    wr(1'b0, 8'h11);
    set_irq(8'h04); pulse_ack;
    set_irq(8'h0C);
    check("R5 level2 does not block", {7'd0, int_out}, 8'h01);
    pulse_ack;
    check("R5 level3 granted", {5'd0, ack_level}, 8'h03);
    set_irq(8'h00);

    // R10/R11/R9 special mask mode
    wr(1'b0, 8'h10);
    set_irq(8'h02); pulse_ack;
    wr(1'b1, 8'h02);
    wr(1'b0, 8'h68);
    set_irq(8'h0A);
    check("R10 in-service ignored", {7'd0, int_out}, 8'h01);
    pulse_ack;
    check("R10 grant below in-service", {5'd0, ack_level}, 8'h03);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R11 masked bit skipped", v, 8'h02);
    set_irq(8'h1A);
    check("R9 mode kept without enable", {7'd0, int_out}, 8'h01);
    wr(1'b0, 8'h48);
    check("R9 mode cleared", {7'd0, int_out}, 8'h00);
    set_irq(8'h00);

    // R8 rotation and specific end of service
    wr(1'b0, 8'h10);
    set_irq(8'h01); pulse_ack;
    wr(1'b0, 8'hA0);
    set_irq(8'h00);
    set_irq(8'h21);
    pulse_ack;
    check("R8 rotated priority", {5'd0, ack_level}, 8'h05);
    wr(1'b0, 8'h65);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R8 specific clear", v, 8'h00);
    check("R8 level0 unblocked", {7'd0, int_out}, 8'h01);
    set_irq(8'h00);

    // R13 ack and end of service together
    wr(1'b0, 8'h10);
    set_irq(8'h02); pulse_ack;
    set_irq(8'h03);
    ack = 1'b1; wr_en = 1'b1; a0 = 1'b0; wdata = 8'h20;
    @(negedge clk);
    ack = 1'b0; wr_en = 1'b0;
    check("R13 ack level", {5'd0, ack_level}, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R13 in-service both applied", v, 8'h01);
    set_irq(8'h00);

    // R12 init clears state and read select
    wr(1'b1, 8'hF0);
    set_irq(8'h01);
    wr(1'b0, 8'h0B);
    wr(1'b0, 8'h10);
    rd(1'b1, v); check("R12 mask cleared", v, 8'h00);
    rd(1'b0, v); check("R12 read select pending", v, 8'h01);
    set_irq(8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule